// File: doc/BRIEF.md
# Guarded Background Offset and Gain Calibration Loop

This block trims the offset and gain coefficients of a converter's digital corrector while conversion carries on. Each valid input sample comes with a signed offset-error feature and a signed gain-error feature, supplied from outside. The block sums these features over fixed frames of 2^FRAME_LOG2 valid samples. When an update falls due, it subtracts a right-shifted copy of each frame sum from the matching coefficient. The new value is clamped to programmable bounds.

Every frame is screened before it is allowed to move a coefficient. A frame is frozen if too many of its samples sit at a full-scale code, or if its mean sample magnitude falls outside a programmable window. A frozen frame never moves the coefficients. Updates fall due every N frames, or on an event pulse. The frame that follows an update is an evaluation frame. It compares a residual metric against the metric of the frame that caused the update. The update is undone if the residual got worse, or if the evaluation frame was itself frozen. A sticky low-confidence flag rises when frozen frames run on too long. All configuration and status sit behind a small register port.

Top module: `bg_cal_loop`

## Requirements
- R1: After reset, coef_off equals OFF_INIT (0), coef_gain equals GAIN_INIT (16384), and the status register (address 7) reads 0. Register 0 reads 0x0104, which is interval 1 and shift 4.
- R2: A frame is 2^FRAME_LOG2 valid samples (16 by default). At the edge that takes a frame's last sample, an update sets each coefficient to clamp(c - (S >>> k)), where S is the frame sum of its error feature and k is the 4-bit shift in register 0 bits [3:0] (0 to 15). The result is visible in the next cycle.
- R3: Register 0 bits [15:8] hold the interval N. An update falls due at the end of a non-evaluation frame once the count of non-evaluation frames since the last update, including this frame, reaches N. A value of 0 or 1 means every frame.
- R4: A pulse on evt makes an update due at the next unfrozen non-evaluation frame end, whatever the interval.
- R5: A sample is clipped when it equals the largest positive or the most negative code. A frame whose clipped-sample count is greater than register 1 bits [7:0] is frozen. A count equal to the threshold is not frozen. Status bit 0 shows whether the last completed frame was frozen.
- R6: A frame is frozen when floor(sum of |sample| / 2^FRAME_LOG2) is below register 2 bits [15:0] or above bits [31:16]. Both bounds are inclusive passes.
- R7: A frozen frame leaves both coefficients unchanged. A pending event stays pending and is applied at the next unfrozen frame end.
- R8: The frame after an update is an evaluation frame. Its metric is |S_off| + |S_gain|. If this metric is strictly greater than the metric of the frame that caused the update, both coefficients return to their values before the update, and sticky status bit 2 is set; writing 1 to bit 2 clears it. If the metric is equal or smaller, the new values become the stable ones.
- R9: A frozen evaluation frame always rolls back to the values before the update, and sets status bit 2.
- R10: Updated coefficients saturate to signed bounds: the offset bounds are in register 3 and the gain bounds in register 4, each with the minimum in bits [15:0] and the maximum in bits [31:16]. Writing register 5 (offset) or register 6 (gain) loads a coefficient and its stable copy directly.
- R11: Sticky status bit 1 sets when the number of consecutive frozen frames reaches register 1 bits [15:8]. An unfrozen frame restarts the count but leaves the bit set. Writing 1 to bit 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample and error features valid this cycle |
| smp | input | DW | Signed raw sample, used by the guards |
| off_err | input | EW | Signed offset-error feature |
| gain_err | input | EW | Signed gain-error feature |
| evt | input | 1 | Pulse that requests an update |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data (combinational) |
| coef_off | output | CW | Offset coefficient driven to the corrector |
| coef_gain | output | CW | Gain coefficient driven to the corrector |

## Verification
The assertions check several rules on every cycle:
- a coefficient changes only at a frame end or on a register write;
- a frozen non-evaluation frame leaves both coefficients untouched;
- a rollback restores exactly the stable copies;
- an update lands inside the bounds;
- the evaluation state lasts one frame;
- the low-confidence flag holds until it is cleared.

Only the bench scenarios can show the arithmetic and the scheduling. These include the shifted update across every shift value, the interval count, an event that waits through a frozen frame, and the exact threshold and window edges. They also include strict-versus-equal metric comparison and the consecutive-frame count behind the low-confidence flag.

// File: rtl/bg_cal_loop.sv
module bg_cal_loop #(
  parameter int DW         = 12,
  parameter int EW         = 16,
  parameter int CW         = 16,
  parameter int FRAME_LOG2 = 4,
  parameter int RW         = 32,
  parameter int OFF_INIT   = 0,
  parameter int GAIN_INIT  = 16384
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] smp,
  input  logic signed [EW-1:0] off_err,
  input  logic signed [EW-1:0] gain_err,
  input  logic                 evt,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [RW-1:0]        reg_wdata,
  output logic [RW-1:0]        reg_rdata,
  output logic signed [CW-1:0] coef_off,
  output logic signed [CW-1:0] coef_gain
);

  localparam int AW  = EW + FRAME_LOG2;
  localparam int MW  = DW + FRAME_LOG2;
  localparam int CCW = FRAME_LOG2 + 1;
  localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic [3:0]  mu;
  logic [7:0]  ivl, clip_thr, conf_lim, fs, fzc;
  logic [15:0] mag_lo, mag_hi;
  logic signed [CW-1:0] bmin [2];
  logic signed [CW-1:0] bmax [2];
  logic signed [CW-1:0] coef [2];
  logic signed [CW-1:0] stab [2];
  logic signed [CW-1:0] cand [2];
  logic signed [AW-1:0] acc [2];
  logic signed [AW-1:0] acc_nx [2];
  logic signed [AW-1:0] step [2];
  logic signed [AW:0]   diff [2];
  logic [AW-1:0]        amag [2];
  logic signed [EW-1:0] err_in [2];
  logic [MW-1:0]   mag_sum, mag_nx;
  logic [CCW-1:0]  clip_cnt, clip_nx;
  logic [FRAME_LOG2-1:0] fcnt;
  logic [AW:0]     base, metric;
  logic ev, pend, frz_q, lowconf, rb;

  assign err_in[0] = off_err;
  assign err_in[1] = gain_err;

  wire [DW-1:0] smag    = smp[DW-1] ? DW'(-smp) : DW'(smp);
  wire          is_clip = (smp == SMAX) || (smp == SMIN);
  assign mag_nx  = mag_sum + MW'(smag);
  assign clip_nx = clip_cnt + CCW'(is_clip);
  wire [DW-1:0] mean = mag_nx[MW-1:FRAME_LOG2];

  wire fend = smp_vld && (&fcnt);
  wire frz  = (16'(clip_nx) > 16'(clip_thr)) || (16'(mean) < mag_lo) || (16'(mean) > mag_hi);

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      acc_nx[i] = acc[i] + AW'(err_in[i]);
      step[i]   = acc_nx[i] >>> mu;
      diff[i]   = (AW+1)'(coef[i]) - (AW+1)'(step[i]);
      if (diff[i] < (AW+1)'(bmin[i]))      cand[i] = bmin[i];
      else if (diff[i] > (AW+1)'(bmax[i])) cand[i] = bmax[i];
      else                                 cand[i] = CW'(diff[i]);
      amag[i] = acc_nx[i][AW-1] ? AW'(-acc_nx[i]) : AW'(acc_nx[i]);
    end
  end
  assign metric = {1'b0, amag[0]} + {1'b0, amag[1]};

  wire [8:0] fs_inc  = {1'b0, fs} + 9'd1;
  wire [8:0] fzc_inc = {1'b0, fzc} + 9'd1;
  wire due    = pend || (fs_inc >= {1'b0, ivl});
  wire upd    = fend && !ev && !frz && due;
  wire keep   = fend && ev && !frz && (metric <= base);
  wire roll   = fend && ev && !keep;
  wire lc_set = fend && frz && (fzc_inc >= {1'b0, conf_lim});
  wire lc_clr = reg_we && (reg_addr == 3'd7) && reg_wdata[1];
  wire rb_clr = reg_we && (reg_addr == 3'd7) && reg_wdata[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        coef[i] <= (i == 0) ? CW'(OFF_INIT) : CW'(GAIN_INIT);
        stab[i] <= (i == 0) ? CW'(OFF_INIT) : CW'(GAIN_INIT);
        bmin[i] <= {1'b1, {(CW-1){1'b0}}};
        bmax[i] <= {1'b0, {(CW-1){1'b1}}};
        acc[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (smp_vld) acc[i] <= fend ? '0 : acc_nx[i];
        if (reg_we && reg_addr == 3'(3 + i)) begin
          bmin[i] <= reg_wdata[CW-1:0];
          bmax[i] <= reg_wdata[CW +: CW];
        end
        if (reg_we && reg_addr == 3'(5 + i)) begin
          coef[i] <= reg_wdata[CW-1:0];
          stab[i] <= reg_wdata[CW-1:0];
        end else if (upd) begin
          stab[i] <= coef[i];
          coef[i] <= cand[i];
        end else if (roll) begin
          coef[i] <= stab[i];
        end else if (keep) begin
          stab[i] <= coef[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt <= '0; mag_sum <= '0; clip_cnt <= '0;
      ev <= 1'b0; pend <= 1'b0; fs <= '0; fzc <= '0; base <= '0;
      frz_q <= 1'b0; lowconf <= 1'b0; rb <= 1'b0;
    end else begin
      if (smp_vld) begin
        fcnt     <= fcnt + 1'b1;
        mag_sum  <= fend ? '0 : mag_nx;
        clip_cnt <= fend ? '0 : clip_nx;
      end
      pend <= (upd ? 1'b0 : pend) | evt;
      if (upd)                              fs <= '0;
      else if (fend && !ev && fs != 8'hFF)  fs <= fs + 1'b1;
      if (upd)       ev <= 1'b1;
      else if (fend) ev <= 1'b0;
      if (upd) base <= metric;
      if (fend) begin
        frz_q <= frz;
        fzc   <= frz ? (fzc == 8'hFF ? fzc : fzc + 1'b1) : 8'd0;
      end
      lowconf <= lc_set | (lowconf & ~lc_clr);
      rb      <= roll | (rb & ~rb_clr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mu <= 4'd4; ivl <= 8'd1; clip_thr <= 8'd0; conf_lim <= 8'd8;
      mag_lo <= 16'd0; mag_hi <= 16'hFFFF;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: begin mu <= reg_wdata[3:0]; ivl <= reg_wdata[15:8]; end
        3'd1: begin clip_thr <= reg_wdata[7:0]; conf_lim <= reg_wdata[15:8]; end
        3'd2: begin mag_lo <= reg_wdata[15:0]; mag_hi <= reg_wdata[31:16]; end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = RW'({ivl, 4'd0, mu});
      3'd1:    reg_rdata = RW'({conf_lim, clip_thr});
      3'd2:    reg_rdata = RW'({mag_hi, mag_lo});
      3'd3:    reg_rdata = RW'({bmax[0], bmin[0]});
      3'd4:    reg_rdata = RW'({bmax[1], bmin[1]});
      3'd5:    reg_rdata = RW'(coef[0]);
      3'd6:    reg_rdata = RW'(coef[1]);
      default: reg_rdata = RW'({ev, rb, lowconf, frz_q});
    endcase
  end

  assign coef_off  = coef[0];
  assign coef_gain = coef[1];

  wire signed [CW-1:0] stab_o = stab[0];
  wire signed [CW-1:0] stab_g = stab[1];
  wire signed [CW-1:0] bmin_o = bmin[0];
  wire signed [CW-1:0] bmax_o = bmax[0];
  wire signed [CW-1:0] bmin_g = bmin[1];
  wire signed [CW-1:0] bmax_g = bmax[1];

endmodule

// File: rtl/bg_cal_loop_chk.sv
module bg_cal_loop_chk #(
  parameter int CW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic                 fend,
  input logic                 frz,
  input logic                 ev,
  input logic                 upd,
  input logic                 roll,
  input logic                 lowconf,
  input logic                 lc_clr,
  input logic signed [CW-1:0] coef_off,
  input logic signed [CW-1:0] coef_gain,
  input logic signed [CW-1:0] stab_o,
  input logic signed [CW-1:0] stab_g,
  input logic signed [CW-1:0] bmin_o,
  input logic signed [CW-1:0] bmax_o,
  input logic signed [CW-1:0] bmin_g,
  input logic signed [CW-1:0] bmax_g
);

  // R2
  frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fend && !reg_we |=> $stable(coef_off) && $stable(coef_gain));

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fend && frz && !ev && !reg_we |=> $stable(coef_off) && $stable(coef_gain));

  // R8
  rollback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll && !reg_we |=> (coef_off == $past(stab_o)) && (coef_gain == $past(stab_g)));

  // R8
  eval_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev && fend |=> !ev);

  // R10
  coef_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !reg_we && (bmin_o <= bmax_o) && (bmin_g <= bmax_g) |=>
      (coef_off >= bmin_o) && (coef_off <= bmax_o) &&
      (coef_gain >= bmin_g) && (coef_gain <= bmax_g));

  // R11
  lowconf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lowconf && !lc_clr |=> lowconf);

endmodule

bind bg_cal_loop bg_cal_loop_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .fend(fend), .frz(frz), .ev(ev),
  .upd(upd), .roll(roll), .lowconf(lowconf), .lc_clr(lc_clr),
  .coef_off(coef_off), .coef_gain(coef_gain), .stab_o(stab_o), .stab_g(stab_g),
  .bmin_o(bmin_o), .bmax_o(bmax_o), .bmin_g(bmin_g), .bmax_g(bmax_g));

// File: tb/sim_bg_cal_loop.sv
`timescale 1ns/1ps
module sim_bg_cal_loop;
  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_vld = 1'b0, evt = 1'b0, reg_we = 1'b0;
  logic signed [11:0] smp = '0;
  logic signed [15:0] off_err = '0, gain_err = '0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic signed [15:0] coef_off, coef_gain;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bg_cal_loop u0 (.clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
    .off_err(off_err), .gain_err(gain_err), .evt(evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .coef_off(coef_off), .coef_gain(coef_gain));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); reg_addr = 3'(a); #1; v = int'(reg_rdata);
  endtask

  task automatic frame(int v, int oe, int ge, int nclip);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      smp_vld = 1'b1; smp = (i < nclip) ? 12'sd2047 : 12'(v);
      off_err = 16'(oe); gain_err = 16'(ge);
    end
    @(negedge clk); smp_vld = 1'b0;
  endtask

  task automatic pulse_evt();
    @(negedge clk); evt = 1'b1;
    @(negedge clk); evt = 1'b0;
  endtask

  function automatic int clampf(int x, int lo, int hi);
    return (x < lo) ? lo : (x > hi) ? hi : x;
  endfunction

  function automatic int nxt(int c, int e, int k);
    return clampf(c - ((e * 16) >>> k), -32768, 32767);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int s;
    int evals[4] = '{37, -1000, 1, -3};
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 coef_off", int'(coef_off), 0);
    chk("R1 coef_gain", int'(coef_gain), 16384);
    rd(7, s); chk("R1 status", s, 0);
    rd(0, s); chk("R1 reg0", s, 32'h0104);

    // R2 sweep of every shift with several error values; R8 keep on quiet eval
    for (int k = 0; k < 16; k++) begin
      for (int j = 0; j < 4; j++) begin
        wr(0, {16'd0, 8'd1, 4'd0, 4'(k)});
        wr(5, 32'd100); wr(6, 32'd16384);
        frame(100, evals[j], -evals[j], 0);
        chk("R2 offset update", int'(coef_off), nxt(100, evals[j], k));
        chk("R2 gain update", int'(coef_gain), nxt(16384, -evals[j], k));
        frame(100, 0, 0, 0);
        chk("R8 keep offset", int'(coef_off), nxt(100, evals[j], k));
        chk("R8 keep gain", int'(coef_gain), nxt(16384, -evals[j], k));
      end
    end

    // R3 interval of three frames
    wr(0, 32'h0300); wr(5, 32'd100); wr(6, 32'd16384);
    frame(100, 2, 0, 0); chk("R3 frame1 no update", int'(coef_off), 100);
    frame(100, 2, 0, 0); chk("R3 frame2 no update", int'(coef_off), 100);
    frame(100, 2, 0, 0); chk("R3 frame3 update", int'(coef_off), 68);
    frame(100, 0, 0, 0); chk("R3 eval keep", int'(coef_off), 68);

    // R4 event forces update regardless of interval
    wr(0, 32'hFF00);
    pulse_evt();
    frame(100, 1, 0, 0); chk("R4 event update", int'(coef_off), 52);
    frame(100, 0, 0, 0); chk("R4 eval keep", int'(coef_off), 52);
    frame(100, 1, 0, 0); chk("R4 no event no update", int'(coef_off), 52);

    // R7 pending event waits through a frozen frame (threshold 0, one clip)
    pulse_evt();
    frame(100, 1, 0, 1); chk("R7 frozen holds", int'(coef_off), 52);
    rd(7, s); chk("R5 status frozen", s & 1, 1);
    frame(100, 1, 0, 0); chk("R7 pending applied", int'(coef_off), 36);
    frame(100, 0, 0, 0); chk("R7 eval keep", int'(coef_off), 36);
    rd(7, s); chk("R5 status not frozen", s & 1, 0);

    // R5 clip threshold boundary
    wr(1, 32'h0801); wr(0, 32'h0100);
    frame(100, 1, 0, 2); chk("R5 count above threshold frozen", int'(coef_off), 36);
    frame(100, 1, 0, 1); chk("R5 count equal threshold updates", int'(coef_off), 20);
    frame(100, 0, 0, 0); chk("R5 eval keep", int'(coef_off), 20);

    // R6 magnitude window edges
    wr(2, {16'd500, 16'd50});
    frame(49, 1, 0, 0);  chk("R6 below window frozen", int'(coef_off), 20);
    frame(50, 1, 0, 0);  chk("R6 low edge passes", int'(coef_off), 4);
    frame(500, 0, 0, 0); chk("R6 high edge passes", int'(coef_off), 4);
    frame(501, 1, 0, 0); chk("R6 above window frozen", int'(coef_off), 4);
    frame(-300, 1, 0, 0); chk("R6 negative sample magnitude", int'(coef_off), -12);
    frame(100, 0, 0, 0); chk("R6 eval keep", int'(coef_off), -12);

    // R8 rollback when metric rises, keep when equal
    wr(5, 32'd100);
    frame(100, 10, 0, 0);  chk("R8 update", int'(coef_off), -60);
    frame(100, 20, 0, 0);  chk("R8 worse rolls back", int'(coef_off), 100);
    rd(7, s); chk("R8 rollback flag", (s >> 2) & 1, 1);
    wr(7, 32'h4);
    rd(7, s); chk("R8 rollback flag cleared", (s >> 2) & 1, 0);
    frame(100, 10, 0, 0);  chk("R8 update again", int'(coef_off), -60);
    frame(100, -10, 0, 0); chk("R8 equal metric keeps", int'(coef_off), -60);
    frame(100, 10, 0, 0);  chk("R8 update third", int'(coef_off), -220);
    frame(100, 0, 11, 0);  chk("R8 gain term worsens metric", int'(coef_off), -60);
    wr(7, 32'h4);

    // R9 frozen evaluation frame rolls back
    wr(1, 32'h0801);
    frame(100, 10, 0, 0); chk("R9 update", int'(coef_off), -220);
    frame(100, 0, 0, 2);  chk("R9 frozen eval rolls back", int'(coef_off), -60);
    rd(7, s); chk("R9 rollback flag", (s >> 2) & 1, 1);
    wr(7, 32'h4);

    // R10 saturation at programmed bounds
    wr(5, 32'd100); wr(3, {16'd200, 16'(-50)});
    frame(100, -100, 0, 0); chk("R10 clamp at max", int'(coef_off), 200);
    frame(100, 0, 0, 0);    chk("R10 eval keep max", int'(coef_off), 200);
    frame(100, 100, 0, 0);  chk("R10 clamp at min", int'(coef_off), -50);
    frame(100, 0, 0, 0);    chk("R10 eval keep min", int'(coef_off), -50);
    wr(4, {16'd16500, 16'd16300}); wr(6, 32'd16384);
    frame(100, 0, -20, 0);  chk("R10 gain clamp at max", int'(coef_gain), 16500);
    frame(100, 0, 0, 0);    chk("R10 gain eval keep", int'(coef_gain), 16500);

    // R11 low-confidence flag
    wr(0, 32'hFF00); wr(1, 32'h0301);
    frame(100, 0, 0, 2); frame(100, 0, 0, 2);
    rd(7, s); chk("R11 two frozen below limit", (s >> 1) & 1, 0);
    frame(100, 0, 0, 2);
    rd(7, s); chk("R11 limit reached", (s >> 1) & 1, 1);
    chk("R7 coef held while frozen", int'(coef_off), -50);
    frame(100, 0, 0, 0);
    rd(7, s); chk("R11 sticky after good frame", (s >> 1) & 1, 1);
    wr(7, 32'h2);
    rd(7, s); chk("R11 cleared by write", (s >> 1) & 1, 0);
    frame(100, 0, 0, 2); frame(100, 0, 0, 2);
    rd(7, s); chk("R11 count restarted", (s >> 1) & 1, 0);
    frame(100, 0, 0, 2);
    rd(7, s); chk("R11 set again", (s >> 1) & 1, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule